// File: doc/BRIEF.md
# Two-Master Bus Ownership Arbiter

This block decides who owns a shared external bus: the on-chip master or a single external master. It watches an active-low request from the external master, a "needs the bus" flag from the on-chip side, a flag saying whether the current on-chip request outranks the external device, and the sampled active-low bus-busy line. From these it drives an active-low grant to the external master and an "owns bus" flag to the on-chip master. It also produces the value and enable for the bus-busy pin and for the transfer-start pin, so the pad ring only has to tri-state them.

The arbiter is a four-state Moore machine with the states idle, external owner, bus wait and on-chip owner. All outputs depend only on registered state, so each decision shows at the pins one clock after the inputs that caused it. When a higher-ranked on-chip request arrives while the external master holds the bus, the grant is withdrawn at once. The arbiter then sits in bus wait until the external master lets bus-busy go high. Only then does the on-chip master take the bus. There is no data stream at this block's edge, so every pin is a plain control level.

Top module: `busarb_top`

## Requirements
- R1: A synchronous active-high reset puts the arbiter in idle: `grant_n`=1, `busy_oe`=0, `ts_oe`=0, `int_owns`=0.
- R2: In idle, a lone on-chip need moves to on-chip owner and a lone external request (`ext_req_n`=0) moves to external owner. If both arrive together, on-chip owner is chosen when `int_hi_pri`=1 and external owner otherwise. With neither, idle holds.
- R3: In external owner `grant_n`=0. When `ext_req_n`=1 and `busy_in_n`=1 and there is no preemption, the arbiter returns to idle. Otherwise it stays.
- R4: In external owner, `int_need`=1 with `int_hi_pri`=1 moves to bus wait and negates the grant on the next cycle. This takes precedence over a release in the same cycle.
- R5: Bus wait keeps `grant_n`=1 and both bus pins undriven. It holds while `busy_in_n`=0 and moves to on-chip owner on the first cycle `busy_in_n`=1 is sampled.
- R6: In on-chip owner `int_owns`=1, `busy_oe`=1 and `busy_drv`=0. The state holds while `int_need`=1 unless a lower-ranked request meets an external request.
- R7: On-chip owner returns to idle when `int_need`=0, or when `ext_req_n`=0 with `int_hi_pri`=0.
- R8: `ts_oe`=1 exactly in on-chip owner. `ts_drv`=0 only on the first cycle of each on-chip tenure and is 1 on every other cycle.
- R9: `grant_n`=0 and `busy_oe`=1 never occur together. `busy_drv` reads 1 whenever `busy_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_req_n | input | 1 | External master bus request, active low |
| int_need | input | 1 | On-chip master needs the bus |
| int_hi_pri | input | 1 | On-chip request outranks the external device |
| busy_in_n | input | 1 | Sampled bus-busy line, active low |
| grant_n | output | 1 | Bus grant to the external master, active low |
| busy_drv | output | 1 | Value to drive on bus-busy |
| busy_oe | output | 1 | Output enable for bus-busy |
| ts_drv | output | 1 | Value to drive on transfer start |
| ts_oe | output | 1 | Output enable for transfer start |
| int_owns | output | 1 | On-chip master owns the bus |

## Verification
The block has no parameters, so the bench builds it exactly as shipped. Its whole decision space is 4 states times 16 input combinations. That space is small enough to reach every (state, input) pair directly: the bench resets, steers the arbiter into each state by a known sequence, applies each combination, and compares against an arithmetic model. A long pseudo-random walk then follows, which covers back-to-back tenures and the single-cycle transfer-start pulse across repeated entries.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_EXT  = 2'd1,
    ARB_WAIT = 2'd2,
    ARB_INT  = 2'd3
  } arb_state_t;
endpackage

// File: rtl/busarb_fsm.sv
module busarb_fsm
  import busarb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_req_n,
  input  logic       int_need,
  input  logic       int_hi_pri,
  input  logic       busy_in_n,
  output arb_state_t state_q
);
  arb_state_t state_d;
  logic ext_req, preempt, ext_release, ext_beats_int;

  assign ext_req       = ~ext_req_n;
  assign preempt       = int_need & int_hi_pri;
  assign ext_release   = ext_req_n & busy_in_n;
  assign ext_beats_int = ext_req & ~int_hi_pri;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_IDLE: begin
        if (int_need && (int_hi_pri || !ext_req)) state_d = ARB_INT;
        else if (ext_req)                          state_d = ARB_EXT;
      end
      ARB_EXT: begin
        if (preempt)          state_d = ARB_WAIT;
        else if (ext_release) state_d = ARB_IDLE;
      end
      ARB_WAIT: begin
        if (busy_in_n) state_d = ARB_INT;
      end
      ARB_INT: begin
        if (!int_need || ext_beats_int) state_d = ARB_IDLE;
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ARB_IDLE;
    else     state_q <= state_d;
  end

  // R4
  ext_no_direct_int_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ARB_EXT) |=> (state_q != ARB_INT));
  // R5
  wait_holds_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ARB_WAIT && !busy_in_n) |=> (state_q == ARB_WAIT));
endmodule

// File: rtl/busarb_pins.sv
module busarb_pins
  import busarb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  arb_state_t state_q,
  output logic       grant_n,
  output logic       busy_drv,
  output logic       busy_oe,
  output logic       ts_drv,
  output logic       ts_oe,
  output logic       int_owns
);
  logic own_now, own_prev_q;

  assign own_now  = (state_q == ARB_INT);
  assign int_owns = own_now;
  assign grant_n  = (state_q != ARB_EXT);
  assign busy_oe  = own_now;
  assign busy_drv = ~own_now;
  assign ts_oe    = own_now;
  assign ts_drv   = ~(own_now & ~own_prev_q);

  always_ff @(posedge clk) begin
    if (rst) own_prev_q <= 1'b0;
    else     own_prev_q <= own_now;
  end

  // R9
  grant_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!grant_n && busy_oe));
  // R8
  ts_only_driven_chk: assert property (@(posedge clk) disable iff (rst)
    !ts_drv |-> ts_oe);
  // R8
  ts_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !ts_drv |=> ts_drv);
endmodule

// File: rtl/busarb_top.sv
module busarb_top
  import busarb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ext_req_n,
  input  logic int_need,
  input  logic int_hi_pri,
  input  logic busy_in_n,
  output logic grant_n,
  output logic busy_drv,
  output logic busy_oe,
  output logic ts_drv,
  output logic ts_oe,
  output logic int_owns
);
  arb_state_t state_q;

  busarb_fsm u_fsm (
    .clk(clk), .rst(rst), .ext_req_n(ext_req_n), .int_need(int_need),
    .int_hi_pri(int_hi_pri), .busy_in_n(busy_in_n), .state_q(state_q)
  );

  busarb_pins u_pins (
    .clk(clk), .rst(rst), .state_q(state_q), .grant_n(grant_n),
    .busy_drv(busy_drv), .busy_oe(busy_oe), .ts_drv(ts_drv),
    .ts_oe(ts_oe), .int_owns(int_owns)
  );

  // R6
  own_drives_busy_chk: assert property (@(posedge clk) disable iff (rst)
    int_owns |-> (busy_oe && !busy_drv && grant_n));
  // R8
  ts_on_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(int_owns) |-> !ts_drv);
endmodule

// File: tb/busarb_top_tb.sv
module busarb_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_req_n = 1'b1, int_need = 1'b0, int_hi_pri = 1'b0, busy_in_n = 1'b1;
  logic grant_n, busy_drv, busy_oe, ts_drv, ts_oe, int_owns;
  int vectors = 0, miscompares = 0;
  int ms = 0, mprev = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  busarb_top u_dut (
    .clk(clk), .rst(rst), .ext_req_n(ext_req_n), .int_need(int_need),
    .int_hi_pri(int_hi_pri), .busy_in_n(busy_in_n), .grant_n(grant_n),
    .busy_drv(busy_drv), .busy_oe(busy_oe), .ts_drv(ts_drv),
    .ts_oe(ts_oe), .int_owns(int_owns)
  );

  // states: 0 idle, 1 external owner, 2 bus wait, 3 on-chip owner
  function automatic int nxt(int s, logic er_n, logic need, logic hi, logic bz_n);
    case (s)
      0: begin
        if (!er_n && need) return hi ? 3 : 1;
        if (need) return 3;
        if (!er_n) return 1;
        return 0;
      end
      1: begin
        if (need && hi) return 2;
        if (er_n && bz_n) return 0;
        return 1;
      end
      2: return bz_n ? 3 : 2;
      default: begin
        if (!need) return 0;
        if (!er_n && !hi) return 0;
        return 3;
      end
    endcase
  endfunction

  function automatic string tag(int s, int n);
    case (s)
      0: return "R2";
      1: return (n == 2) ? "R4" : "R3";
      2: return "R5";
      default: return (n == 3) ? "R6" : "R7";
    endcase
  endfunction

  task automatic check(string rq);
    logic [1:0] a_exp, b_exp, c_exp;
    bit bad = 1'b0;
    a_exp = {logic'(ms != 1), logic'(ms == 3)};
    b_exp = {logic'(ms == 3), logic'(ms != 3)};
    c_exp = {logic'(ms == 3), logic'(!(ms == 3 && mprev != 3))};
    vectors++;
    if ({grant_n, int_owns} !== a_exp) begin
      bad = 1'b1;
      $display("FAIL %s grant_n/int_owns got %b exp %b", rq, {grant_n, int_owns}, a_exp);
    end
    if ({busy_oe, busy_drv} !== b_exp) begin
      bad = 1'b1;
      $display("FAIL R9 busy_oe/busy_drv got %b exp %b", {busy_oe, busy_drv}, b_exp);
    end
    if ({ts_oe, ts_drv} !== c_exp) begin
      bad = 1'b1;
      $display("FAIL R8 ts_oe/ts_drv got %b exp %b", {ts_oe, ts_drv}, c_exp);
    end
    if (bad) miscompares++;
  endtask

  // inputs applied at a falling edge, checked at the next falling edge
  task automatic step(logic er_n, logic need, logic hi, logic bz_n);
    int n;
    ext_req_n = er_n; int_need = need; int_hi_pri = hi; busy_in_n = bz_n;
    n = nxt(ms, er_n, need, hi, bz_n);
    @(posedge clk);
    @(negedge clk);
    mprev = ms;
    check(tag(ms, n));
    ms = n;
    mprev = mprev; // model of previous state kept for R8
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ext_req_n = 1'b1; int_need = 1'b0; int_hi_pri = 1'b0; busy_in_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    ms = 0; mprev = 0;
    check("R1");
  endtask

  // fix up ordering: model next state must be known before check
  task automatic step2(logic er_n, logic need, logic hi, logic bz_n);
    int n;
    ext_req_n = er_n; int_need = need; int_hi_pri = hi; busy_in_n = bz_n;
    n = nxt(ms, er_n, need, hi, bz_n);
    @(posedge clk);
    @(negedge clk);
    begin
      string t;
      t = tag(ms, n);
      mprev = ms;
      ms = n;
      check(t);
    end
  endtask

  task automatic steer(int target);
    case (target)
      1: step2(1'b0, 1'b0, 1'b0, 1'b1);
      2: begin step2(1'b0, 1'b0, 1'b0, 1'b1); step2(1'b0, 1'b1, 1'b1, 1'b0); end
      3: step2(1'b1, 1'b1, 1'b0, 1'b1);
      default: ;
    endcase
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    @(negedge clk);
    do_reset();                       // R1
    // exhaustive sweep: every state against every input combination
    for (int st = 0; st < 4; st++) begin
      for (int v = 0; v < 16; v++) begin
        do_reset();
        steer(st);
        step2(v[3], v[2], v[1], v[0]);   // R2 R3 R4 R5 R6 R7
        step2(1'b1, 1'b0, 1'b0, 1'b1);   // follow-up, R8 single pulse
      end
    end
    // preemption beats release in the same cycle (R4), then wait holds (R5)
    do_reset();
    steer(1);
    step2(1'b1, 1'b1, 1'b1, 1'b1);
    step2(1'b1, 1'b1, 1'b1, 1'b0);
    step2(1'b1, 1'b1, 1'b1, 1'b1);
    step2(1'b1, 1'b1, 1'b1, 1'b1);
    // pseudo-random walk
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step2(lfsr[0], lfsr[3], lfsr[7], lfsr[11] | lfsr[5]);
    end
    do_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule